// File: doc/BRIEF.md
# Request Command Sequencer for a Ternary Search Co-processor

The sequencer sits between a host request bus and a ternary match array. A host command spans two clock cycles. The first cycle carries a strobe, an opcode, an address or search key, a lookup-type code, a global-mask select and a comparand select. The following cycle carries write data and a result-register select on the same select field. The sequencer turns each accepted command into a single-cycle request to the array, an access on the external SRAM index bus, or both. It also turns array results into index-bus cycles, and it returns read acknowledges for array reads and for pipelined SRAM reads.

A burst-advance input repeats the most recent data or mask write at the next address, one beat per cycle. The host then needs no new address frame for each entry of a table fill. The counter wraps at the top of the address space, and the number of beats has no limit. After reset, every output is held quiet and the sequencer accepts only a configuration write. A configuration write with data bit 0 set enables it.

Top module: `reqseq`

## Requirements
- R1: After reset, idx_oe, arr_req, sram_ce, sram_we and rd_ack are 0. While the enable bit is clear, the only command accepted is a write (opcode 2) whose first-cycle data has target bits [71:70] = 2'b11. Any other command produces no array request and no SRAM cycle. The enable bit takes the value of bit 0 of that write's second-cycle data, and idx_oe shows it from the cycle after the issue cycle.
- R2: A strobed cycle carries the opcode, the first data word, the lookup type, the global-mask select and the comparand select. The next cycle carries the result select and the second data word. The resulting request appears in the cycle after that second cycle. A strobe during the second cycle is ignored. The opcodes are 0 nop, 1 array read, 2 array write, 3 lookup, 4 learn, 5 SRAM read, 6 SRAM write and 7 dual write. The target codes in bits [71:70] of the first word are 00 data, 01 mask, 10 register and 11 configuration.
- R3: For lookup and learn, arr_cmp_sel carries the first-cycle select and arr_res_sel carries the second-cycle select. For every other request, both are 0.
- R4: arr_ltype carries the lookup type for lookup and learn, and is 0 for every other request.
- R5: arr_gmsel carries the mask select for lookup, write and dual write, and is 0 for read and learn.
- R6: The array request uses opcode 1, 2, 3, 4 or 7. arr_addr is bits [14:0] of the first word. arr_wdata is the second word for opcodes 2 and 7, and the first word (the key) for opcodes 3 and 4. An SRAM read or SRAM write raises no array request.
- R7: After an array write to a data or mask target, each idle cycle with burst_adv high issues one array write in the next cycle. That write goes to the previous burst address plus 1, modulo 2^15, with the same target and that cycle's data. After a write to a register or configuration target, burst_adv has no effect.
- R8: In the issue cycle of an SRAM read, SRAM write or dual write, sram_ce is 1 and idx_addr is the command address. sram_we is 0 for an SRAM read and 1 for the other two. A dual write raises its array write in the same cycle.
- R9: rd_ack pulses one cycle after arr_rdone, and 2 cycles after the index-bus cycle of an SRAM read. A new command may be strobed in the issue cycle of an SRAM read, and each read still gets its own acknowledge.
- R10: One cycle after arr_done, idx_addr shows arr_index. For a learn result (arr_learn = 1), sram_ce and sram_we are both 1. For a lookup result, sram_ce equals arr_hit and sram_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stb | input | 1 | Marks the first cycle of a command |
| req_op | input | 3 | Opcode |
| req_crsel | input | 4 | Comparand select (first cycle), result select (second cycle) |
| req_data | input | 72 | Address or key (first cycle), write data (second cycle), burst data |
| req_ltype | input | 2 | Lookup type |
| req_gmsel | input | 3 | Global-mask select |
| burst_adv | input | 1 | Advance the burst address and write one beat |
| arr_rdone | input | 1 | Array read data is ready |
| arr_done | input | 1 | Array lookup or learn result is valid |
| arr_learn | input | 1 | The result belongs to a learn |
| arr_hit | input | 1 | Lookup matched |
| arr_index | input | 15 | Result index |
| arr_req | output | 1 | Single-cycle array request |
| arr_op | output | 3 | Request opcode |
| arr_tgt | output | 2 | Target code |
| arr_addr | output | 15 | Entry address |
| arr_wdata | output | 72 | Write data or search key |
| arr_ltype | output | 2 | Lookup type, gated |
| arr_gmsel | output | 3 | Mask select, gated |
| arr_cmp_sel | output | 4 | Comparand register select |
| arr_res_sel | output | 4 | Result register select |
| idx_oe | output | 1 | Index-bus drive enable (enable bit) |
| idx_addr | output | 15 | Index-bus address |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |
| rd_ack | output | 1 | Read acknowledge |

## Verification
The bench sweeps every opcode with non-zero lookup-type, mask-select and register-select values. A gating error would leak a don't-care field into the array, or would drop one that lookups need. It sends commands while the block is disabled, and holds the strobe high into a second cycle. A sequencer that failed to gate on the enable bit, or that restarted its framing mid-command, would show a stray SRAM or array cycle there. Burst runs cross the wrap from address 0x7FFF to 0, and a burst is tried after a register write. A wrong counter load, a missing wrap or a missing disarm would show up as wrong addresses or phantom writes. Back-to-back SRAM reads and array results check that each read gets its own acknowledge at the right delay, and that learn results drive the write enable.

// File: rtl/reqseq_pkg.sv
package reqseq_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_LOOKUP = 3'd3,
    OP_LEARN  = 3'd4,
    OP_SRD    = 3'd5,
    OP_SWR    = 3'd6,
    OP_DUAL   = 3'd7
  } op_e;

  localparam logic [1:0] TGT_DATA = 2'b00;
  localparam logic [1:0] TGT_MASK = 2'b01;
  localparam logic [1:0] TGT_REG  = 2'b10;
  localparam logic [1:0] TGT_CFG  = 2'b11;

  function automatic logic op_uses_ltype(op_e op);
    return (op == OP_LOOKUP) || (op == OP_LEARN);
  endfunction

  function automatic logic op_uses_gmsel(op_e op);
    return (op == OP_LOOKUP) || (op == OP_WRITE) || (op == OP_DUAL);
  endfunction

  function automatic logic op_uses_regsel(op_e op);
    return (op == OP_LOOKUP) || (op == OP_LEARN);
  endfunction

  function automatic logic op_hits_sram(op_e op);
    return (op == OP_SRD) || (op == OP_SWR) || (op == OP_DUAL);
  endfunction

  function automatic logic op_takes_word1(op_e op);
    return (op == OP_WRITE) || (op == OP_DUAL);
  endfunction

endpackage

// File: rtl/reqseq_capture.sv
module reqseq_capture
  import reqseq_pkg::*;
#(
  parameter int DATA_W = 72,
  parameter int SEL_W  = 4,
  parameter int LT_W   = 2,
  parameter int GM_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  input  logic [2:0]        op,
  input  logic [SEL_W-1:0]  crsel,
  input  logic [DATA_W-1:0] data,
  input  logic [LT_W-1:0]   ltype,
  input  logic [GM_W-1:0]   gmsel,
  output logic              second,
  output logic              issue,
  output op_e               c_op,
  output logic [SEL_W-1:0]  c_cmp,
  output logic [SEL_W-1:0]  c_res,
  output logic [DATA_W-1:0] c_w0,
  output logic [DATA_W-1:0] c_w1,
  output logic [LT_W-1:0]   c_lt,
  output logic [GM_W-1:0]   c_gm
);

  localparam int TGT_HI = DATA_W - 1;

  logic accept;
  logic second_d;
  logic issue_d;

  // A disabled block still takes the configuration write that enables it.
  always_comb begin
    accept   = !second && stb &&
               (en || ((op == 3'(OP_WRITE)) && (data[TGT_HI -: 2] == TGT_CFG)));
    second_d = second ? 1'b0 : accept;
    issue_d  = second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second <= 1'b0;
      issue  <= 1'b0;
    end else begin
      second <= second_d;
      issue  <= issue_d;
    end
  end

  // First-cycle fields.
  always_ff @(posedge clk) begin
    if (accept) begin
      c_op  <= op_e'(op);
      c_cmp <= crsel;
      c_w0  <= data;
      c_lt  <= ltype;
      c_gm  <= gmsel;
    end
  end

  // Second-cycle fields: the select field now names the result register.
  always_ff @(posedge clk) begin
    if (second) begin
      c_res <= crsel;
      c_w1  <= data;
    end
  end

endmodule

// File: rtl/reqseq_burst.sv
module reqseq_burst #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_arm,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [1:0]        load_tgt,
  input  logic              adv,
  input  logic [DATA_W-1:0] adv_data,
  output logic              b_issue,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data,
  output logic [1:0]        b_tgt
);

  logic              armed;
  logic              armed_d;
  logic              b_issue_d;
  logic              step;
  logic [ADDR_W-1:0] cnt_d;

  always_comb begin
    step      = adv && armed && !load;
    armed_d   = load ? load_arm : armed;
    b_issue_d = step;
    cnt_d     = b_addr;
    if (load)      cnt_d = load_addr;
    else if (step) cnt_d = b_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      b_issue <= 1'b0;
    end else begin
      armed   <= armed_d;
      b_issue <= b_issue_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load || step) b_addr <= cnt_d;
    if (load)         b_tgt  <= load_tgt;
    if (step)         b_data <= adv_data;
  end

endmodule

// File: rtl/reqseq_idxbus.sv
module reqseq_idxbus #(
  parameter int IDX_W    = 15,
  parameter int SRAM_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cmd_acc,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_addr,
  input  logic             arr_done,
  input  logic             arr_learn,
  input  logic             arr_hit,
  input  logic [IDX_W-1:0] arr_index,
  input  logic             arr_rdone,
  output logic             idx_oe,
  output logic [IDX_W-1:0] idx_addr,
  output logic             sram_ce,
  output logic             sram_we,
  output logic             rd_ack
);

  logic             res_v;
  logic             res_ce;
  logic             res_we;
  logic [IDX_W-1:0] res_idx;
  logic             ardy;
  logic [SRAM_LAT:0] ack_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v <= 1'b0;
      ardy  <= 1'b0;
    end else begin
      res_v <= arr_done && en;
      ardy  <= arr_rdone && en;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_done) begin
      res_idx <= arr_index;
      res_ce  <= arr_learn || arr_hit;
      res_we  <= arr_learn;
    end
  end

  assign ack_pipe[0] = cmd_acc && !cmd_we;

  // One flop per cycle of SRAM read latency.
  for (genvar s = 0; s < SRAM_LAT; s++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_pipe[s+1] <= 1'b0;
      else        ack_pipe[s+1] <= ack_pipe[s];
    end
  end

  always_comb begin
    idx_oe   = en;
    idx_addr = '0;
    sram_ce  = 1'b0;
    sram_we  = 1'b0;
    if (en && cmd_acc) begin
      idx_addr = cmd_addr;
      sram_ce  = 1'b1;
      sram_we  = cmd_we;
    end else if (en && res_v) begin
      idx_addr = res_idx;
      sram_ce  = res_ce;
      sram_we  = res_we;
    end
    rd_ack = en && (ardy || ack_pipe[SRAM_LAT]);
  end

endmodule

// File: rtl/reqseq.sv
module reqseq
  import reqseq_pkg::*;
#(
  parameter int DATA_W   = 72,
  parameter int ADDR_W   = 15,
  parameter int SEL_W    = 4,
  parameter int LT_W     = 2,
  parameter int GM_W     = 3,
  parameter int SRAM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_stb,
  input  logic [2:0]        req_op,
  input  logic [SEL_W-1:0]  req_crsel,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LT_W-1:0]   req_ltype,
  input  logic [GM_W-1:0]   req_gmsel,
  input  logic              burst_adv,
  input  logic              arr_rdone,
  input  logic              arr_done,
  input  logic              arr_learn,
  input  logic              arr_hit,
  input  logic [ADDR_W-1:0] arr_index,
  output logic              arr_req,
  output logic [2:0]        arr_op,
  output logic [1:0]        arr_tgt,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [LT_W-1:0]   arr_ltype,
  output logic [GM_W-1:0]   arr_gmsel,
  output logic [SEL_W-1:0]  arr_cmp_sel,
  output logic [SEL_W-1:0]  arr_res_sel,
  output logic              idx_oe,
  output logic [ADDR_W-1:0] idx_addr,
  output logic              sram_ce,
  output logic              sram_we,
  output logic              rd_ack
);

  localparam int TGT_HI = DATA_W - 1;

  logic              en;
  logic              en_d;
  logic              second;
  logic              issue;
  op_e               c_op;
  logic [SEL_W-1:0]  c_cmp;
  logic [SEL_W-1:0]  c_res;
  logic [DATA_W-1:0] c_w0;
  logic [DATA_W-1:0] c_w1;
  logic [LT_W-1:0]   c_lt;
  logic [GM_W-1:0]   c_gm;
  logic [1:0]        c_tgt;
  logic              b_issue;
  logic [ADDR_W-1:0] b_addr;
  logic [DATA_W-1:0] b_data;
  logic [1:0]        b_tgt;
  logic              burst_load;
  logic              burst_arm;
  logic              burst_step;
  logic              cfg_wr;
  logic              cmd_arr;
  logic              cmd_sram;

  reqseq_capture #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .LT_W(LT_W), .GM_W(GM_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .en(en), .stb(req_stb), .op(req_op),
    .crsel(req_crsel), .data(req_data), .ltype(req_ltype), .gmsel(req_gmsel),
    .second(second), .issue(issue), .c_op(c_op), .c_cmp(c_cmp), .c_res(c_res),
    .c_w0(c_w0), .c_w1(c_w1), .c_lt(c_lt), .c_gm(c_gm)
  );

  assign c_tgt = c_w0[TGT_HI -: 2];

  // The burst counter loads during the second cycle of a write, so a beat
  // may be requested as early as the write's issue cycle.
  always_comb begin
    burst_load = second && (c_op == OP_WRITE);
    burst_arm  = (c_tgt == TGT_DATA) || (c_tgt == TGT_MASK);
    burst_step = burst_adv && en && !second && !req_stb;
  end

  reqseq_burst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(burst_load), .load_arm(burst_arm),
    .load_addr(c_w0[ADDR_W-1:0]), .load_tgt(c_tgt), .adv(burst_step),
    .adv_data(req_data), .b_issue(b_issue), .b_addr(b_addr), .b_data(b_data),
    .b_tgt(b_tgt)
  );

  always_comb begin
    cfg_wr   = issue && (c_op == OP_WRITE) && (c_tgt == TGT_CFG);
    en_d     = cfg_wr ? c_w1[0] : en;
    cmd_sram = issue && en && op_hits_sram(c_op);
    cmd_arr  = issue && en &&
               ((c_op == OP_READ) || (c_op == OP_LOOKUP) || (c_op == OP_LEARN) ||
                (c_op == OP_DUAL) || ((c_op == OP_WRITE) && (c_tgt != TGT_CFG)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= en_d;
  end

  // Array request: burst beats and command issues never share a cycle.
  always_comb begin
    arr_req     = 1'b0;
    arr_op      = 3'(OP_NOP);
    arr_tgt     = '0;
    arr_addr    = '0;
    arr_wdata   = '0;
    arr_ltype   = '0;
    arr_gmsel   = '0;
    arr_cmp_sel = '0;
    arr_res_sel = '0;
    if (en && b_issue) begin
      arr_req   = 1'b1;
      arr_op    = 3'(OP_WRITE);
      arr_tgt   = b_tgt;
      arr_addr  = b_addr;
      arr_wdata = b_data;
    end else if (cmd_arr) begin
      arr_req   = 1'b1;
      arr_op    = 3'(c_op);
      arr_tgt   = c_tgt;
      arr_addr  = c_w0[ADDR_W-1:0];
      arr_wdata = op_takes_word1(c_op) ? c_w1 : c_w0;
      if (op_uses_ltype(c_op))  arr_ltype = c_lt;
      if (op_uses_gmsel(c_op))  arr_gmsel = c_gm;
      if (op_uses_regsel(c_op)) begin
        arr_cmp_sel = c_cmp;
        arr_res_sel = c_res;
      end
    end
  end

  reqseq_idxbus #(.IDX_W(ADDR_W), .SRAM_LAT(SRAM_LAT)) u_idx (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_acc(cmd_sram),
    .cmd_we(c_op != OP_SRD), .cmd_addr(c_w0[ADDR_W-1:0]),
    .arr_done(arr_done), .arr_learn(arr_learn), .arr_hit(arr_hit),
    .arr_index(arr_index), .arr_rdone(arr_rdone), .idx_oe(idx_oe),
    .idx_addr(idx_addr), .sram_ce(sram_ce), .sram_we(sram_we), .rd_ack(rd_ack)
  );

endmodule

// File: rtl/reqseq_chk.sv
module reqseq_chk
  import reqseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SEL_W  = 4,
  parameter int LT_W   = 2,
  parameter int GM_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arr_req,
  input logic [2:0]        arr_op,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [LT_W-1:0]   arr_ltype,
  input logic [GM_W-1:0]   arr_gmsel,
  input logic [SEL_W-1:0]  arr_cmp_sel,
  input logic [SEL_W-1:0]  arr_res_sel,
  input logic              idx_oe,
  input logic [ADDR_W-1:0] idx_addr,
  input logic              sram_ce,
  input logic              sram_we,
  input logic              rd_ack,
  input logic              arr_done,
  input logic              arr_learn,
  input logic [ADDR_W-1:0] arr_index
);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_oe |-> (!arr_req && !sram_ce && !sram_we && !rd_ack));

  p_regsel_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && (arr_op != 3'(OP_LOOKUP)) && (arr_op != 3'(OP_LEARN)))
      |-> ((arr_cmp_sel == '0) && (arr_res_sel == '0)));

  p_ltype_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && (arr_op != 3'(OP_LOOKUP)) && (arr_op != 3'(OP_LEARN)))
      |-> (arr_ltype == '0));

  p_gmsel_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && ((arr_op == 3'(OP_READ)) || (arr_op == 3'(OP_LEARN))))
      |-> (arr_gmsel == '0));

  p_dual_paired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && (arr_op == 3'(OP_DUAL)))
      |-> (sram_ce && sram_we && (idx_addr == arr_addr)));

  p_learn_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_oe && arr_done && arr_learn)
      |=> (!idx_oe || (sram_ce && sram_we && (idx_addr == $past(arr_index)))));

endmodule

bind reqseq reqseq_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LT_W(LT_W), .GM_W(GM_W)
) u_chk (.*);

// File: tb/reqseq_bench.sv
module reqseq_bench;

  logic        clk;
  logic        rst_n;
  logic        req_stb;
  logic [2:0]  req_op;
  logic [3:0]  req_crsel;
  logic [71:0] req_data;
  logic [1:0]  req_ltype;
  logic [2:0]  req_gmsel;
  logic        burst_adv;
  logic        arr_rdone;
  logic        arr_done;
  logic        arr_learn;
  logic        arr_hit;
  logic [14:0] arr_index;
  logic        arr_req;
  logic [2:0]  arr_op;
  logic [1:0]  arr_tgt;
  logic [14:0] arr_addr;
  logic [71:0] arr_wdata;
  logic [1:0]  arr_ltype;
  logic [2:0]  arr_gmsel;
  logic [3:0]  arr_cmp_sel;
  logic [3:0]  arr_res_sel;
  logic        idx_oe;
  logic [14:0] idx_addr;
  logic        sram_ce;
  logic        sram_we;
  logic        rd_ack;

  int n_chk;
  int n_bad;
  bit finished;

  reqseq u_reqseq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [3:0] cs0, input logic [71:0] d0,
                      input logic [1:0] lt, input logic [2:0] gm,
                      input logic [3:0] cs1, input logic [71:0] d1);
    @(negedge clk);
    req_stb = 1'b1; req_op = op; req_crsel = cs0; req_data = d0;
    req_ltype = lt; req_gmsel = gm;
    @(negedge clk);
    req_stb = 1'b0; req_op = 3'd0; req_crsel = cs1; req_data = d1;
    req_ltype = 2'd0; req_gmsel = 3'd0;
    @(negedge clk);
    req_crsel = 4'd0; req_data = '0;
  endtask

  function automatic logic [71:0] word0(input logic [1:0] tgt, input logic [14:0] a);
    return {tgt, 40'h5A5A5A5A5A, 15'd0, a};
  endfunction

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; req_stb = 0; req_op = 0; req_crsel = 0; req_data = '0;
    req_ltype = 0; req_gmsel = 0; burst_adv = 0; arr_rdone = 0; arr_done = 0;
    arr_learn = 0; arr_hit = 0; arr_index = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset idx_oe", 72'(idx_oe), 72'd0);
    chk("R1 reset arr_req", 72'(arr_req), 72'd0);
    chk("R1 reset ce/we/ack", 72'({sram_ce, sram_we, rd_ack}), 72'd0);
    rst_n = 1'b1;

    // Disabled: commands other than the configuration write do nothing.
    send(3'd6, 4'd0, word0(2'b00, 15'h0123), 2'd0, 3'd0, 4'd0, 72'h1);
    chk("R1 disabled sram", 72'({sram_ce, sram_we}), 72'd0);
    send(3'd2, 4'd0, word0(2'b00, 15'h0040), 2'd0, 3'd0, 4'd0, 72'h7);
    chk("R1 disabled write", 72'(arr_req), 72'd0);
    send(3'd2, 4'd0, word0(2'b11, 15'h0), 2'd0, 3'd0, 4'd0, 72'h1);
    chk("R1 cfg write no array req", 72'(arr_req), 72'd0);
    @(negedge clk);
    chk("R1 enabled", 72'(idx_oe), 72'd1);

    // Sweep all opcodes with non-zero don't-care fields.
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 2; k++) begin
        logic [14:0] a;
        logic [71:0] w0, w1;
        logic [1:0] lt;
        logic [2:0] gm;
        logic [3:0] c0, c1;
        bit ea, es, ew;
        a  = 15'(16'h1111 * (op + 1) + k * 15'h0301);
        w0 = word0(2'b00, a);
        w1 = {8'(op), 8'(k), 56'hC0FFEE0DDBA11};
        lt = 2'(k + 2); gm = 3'(5 - k); c0 = 4'(9 + k); c1 = 4'(6 - k);
        ea = (op == 1) || (op == 2) || (op == 3) || (op == 4) || (op == 7);
        es = (op == 5) || (op == 6) || (op == 7);
        ew = (op == 6) || (op == 7);
        send(3'(op), c0, w0, lt, gm, c1, w1);
        chk("R2 arr_req", 72'(arr_req), 72'(ea));
        chk("R3 cmp_sel", 72'(arr_cmp_sel), (ea && (op == 3 || op == 4)) ? 72'(c0) : 72'd0);
        chk("R3 res_sel", 72'(arr_res_sel), (ea && (op == 3 || op == 4)) ? 72'(c1) : 72'd0);
        chk("R4 ltype", 72'(arr_ltype), (op == 3 || op == 4) ? 72'(lt) : 72'd0);
        chk("R5 gmsel", 72'(arr_gmsel), (op == 3 || op == 2 || op == 7) ? 72'(gm) : 72'd0);
        chk("R6 arr_addr", 72'(arr_addr), ea ? 72'(a) : 72'd0);
        chk("R6 arr_wdata", arr_wdata, !ea ? 72'd0 : ((op == 2 || op == 7) ? w1 : w0));
        chk("R8 sram_ce", 72'(sram_ce), 72'(es));
        chk("R8 sram_we", 72'(sram_we), 72'(ew));
        chk("R8 idx_addr", 72'(idx_addr), es ? 72'(a) : 72'd0);
        @(negedge clk);
        chk("R9 no early ack", 72'(rd_ack), 72'd0);
        @(negedge clk);
        chk("R9 sram read ack", 72'(rd_ack), 72'(op == 5));
        @(negedge clk);
      end
    end

    // Strobe held into the second cycle is ignored.
    @(negedge clk);
    req_stb = 1; req_op = 3'd6; req_data = word0(2'b00, 15'h0AAA);
    @(negedge clk);
    req_data = word0(2'b00, 15'h0BBB);
    @(negedge clk);
    req_stb = 0; req_op = 0; req_data = '0;
    chk("R2 first command idx", 72'(idx_addr), 72'h0AAA);
    @(negedge clk);
    chk("R2 second strobe ignored a", 72'(sram_ce), 72'd0);
    @(negedge clk);
    chk("R2 second strobe ignored b", 72'(sram_ce), 72'd0);

    // No-wait SRAM reads back to back.
    @(negedge clk);
    req_stb = 1; req_op = 3'd5; req_data = word0(2'b00, 15'h0011);
    @(negedge clk);
    req_stb = 0; req_op = 0; req_data = '0;
    @(negedge clk);
    req_stb = 1; req_op = 3'd5; req_data = word0(2'b00, 15'h0022);
    chk("R9 first read issued", 72'(idx_addr), 72'h0011);
    @(negedge clk);
    req_stb = 0; req_op = 0; req_data = '0;
    chk("R9 gap ack", 72'(rd_ack), 72'd0);
    @(negedge clk);
    chk("R9 second read issued", 72'({sram_ce, idx_addr}), 72'({1'b1, 15'h0022}));
    chk("R9 first ack", 72'(rd_ack), 72'd1);
    @(negedge clk);
    chk("R9 between acks", 72'(rd_ack), 72'd0);
    @(negedge clk);
    chk("R9 second ack", 72'(rd_ack), 72'd1);

    // Array read acknowledge.
    @(negedge clk); arr_rdone = 1;
    @(negedge clk); arr_rdone = 0;
    chk("R9 array ack", 72'(rd_ack), 72'd1);
    @(negedge clk);
    chk("R9 array ack single", 72'(rd_ack), 72'd0);

    // Array results on the index bus.
    for (int m = 0; m < 3; m++) begin
      logic [14:0] ix;
      ix = 15'(16'h1234 + m * 16'h0777);
      @(negedge clk);
      arr_done = 1; arr_learn = (m == 2); arr_hit = (m == 0); arr_index = ix;
      @(negedge clk);
      arr_done = 0; arr_learn = 0; arr_hit = 0; arr_index = '0;
      chk("R10 result index", 72'(idx_addr), 72'(ix));
      chk("R10 result ce", 72'(sram_ce), 72'(m != 1));
      chk("R10 result we", 72'(sram_we), 72'(m == 2));
    end

    // Burst across the top of the address space, mask target.
    send(3'd2, 4'd0, word0(2'b01, 15'h7FFD), 2'd0, 3'd0, 4'd0, 72'hAB);
    for (int b = 1; b <= 5; b++) begin
      burst_adv = 1; req_data = 72'(b * 72'h1001);
      @(negedge clk);
      chk("R7 burst req", 72'(arr_req), 72'd1);
      chk("R7 burst addr", 72'(arr_addr), 72'(15'(15'h7FFD + b)));
      chk("R7 burst data", arr_wdata, 72'(b * 72'h1001));
      chk("R7 burst tgt", 72'(arr_tgt), 72'd1);
    end
    burst_adv = 0; req_data = '0;
    @(negedge clk);
    chk("R7 burst stops", 72'(arr_req), 72'd0);

    // Burst after a register write has no effect.
    send(3'd2, 4'd0, word0(2'b10, 15'h0003), 2'd0, 3'd0, 4'd0, 72'h5);
    burst_adv = 1; req_data = 72'h99;
    @(negedge clk);
    chk("R7 burst after reg write", 72'(arr_req), 72'd0);
    @(negedge clk);
    chk("R7 burst after reg write b", 72'(arr_req), 72'd0);
    burst_adv = 0; req_data = '0;

    // Disable again: outputs go quiet.
    send(3'd2, 4'd0, word0(2'b11, 15'h0), 2'd0, 3'd0, 4'd0, 72'h0);
    @(negedge clk);
    chk("R1 disabled again", 72'(idx_oe), 72'd0);
    send(3'd7, 4'd0, word0(2'b00, 15'h0005), 2'd0, 3'd0, 4'd0, 72'h5);
    chk("R1 dual ignored when off", 72'({arr_req, sram_ce}), 72'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule